// File: doc/BRIEF.md
# Vector Register-Group Legality Checker

This block belongs to the decode stage of a vector unit. For each decoded instruction it checks whether the destination and source register indices fit the register-group layout. That layout is set by the current group multiplier, the element width and the operation class. The block presents a registered verdict one cycle after the instruction is strobed in, so the trap logic can act on it without a long combinational path from decode.

The checks cover group alignment, group overlap, multiplier and element-width limits, the masked-destination rule, and the start-index rule for reductions. Source and destination groups are scaled by one, two or four times the multiplier, depending on the class. A fractional multiplier produces a group of one register, rounded up. Executing elements, reading registers and raising the trap are done elsewhere.

A three-state machine holds the verdict:

- `ST_IDLE` means no result this cycle.
- `ST_LEGAL` means the strobed instruction passed every check.
- `ST_ILLEGAL` means it failed at least one check.

From every state there are three transitions. A strobe whose checks pass goes to `ST_LEGAL`. A strobe whose checks fail goes to `ST_ILLEGAL`. A cycle with no strobe goes to `ST_IDLE`. Reset enters `ST_IDLE`.

Top module: `vgrp_legal_chk`

## Requirements
- R1: `res_valid` is 1 exactly in the cycle after a cycle with `in_valid` = 1. `illegal` is 1 only in such a cycle, and only when the strobed instruction fails a check. After reset both outputs are 0.
- R2: `lmul_code` values 0, 1, 2, 3 select a multiplier of 1, 2, 4, 8. Values 5, 6, 7 select 1/8, 1/4, 1/2. Value 4 is illegal for every class. `op_class` values 11 to 15 are illegal.
- R3: The group size for a scale k (1, 2 or 4) is the larger of 1 and ceil(k × multiplier). An index is aligned to a group when it is a multiple of the group size.
- R4: Range [a, a+n) overlaps range [b, b+m) when max(a+n, b+m) − min(a, b) < n + m. Ranges that only touch do not overlap, and two empty ranges never overlap.
- R5: Single-width (class 0) and slide (class 10) operations need `vd` and `vs2` aligned to the 1× group. Single-width also needs `vs1` aligned to that group when `vs1_is_vec` = 1. A scalar `vs1` is not checked.
- R6: Widening (class 1) needs all of the following: multiplier ≤ 4; `sew_log2`+1 ≤ `elen_log2`; `vd` aligned to the 2× group; the 2× `vd` group not overlapping the 1× `vs2` group or a vector `vs1` group; and each source aligned to the 1× group.
- R7: Wide-source widening (class 2) needs all of the following: multiplier ≤ 4; `sew_log2`+1 ≤ `elen_log2`; `vd` and `vs2` aligned to the 2× group; and a vector `vs1` aligned to the 1× group and not overlapping the 2× `vd` group.
- R8: Narrowing (class 3) needs all of the following: multiplier ≤ 4; `sew_log2`+1 ≤ `elen_log2`; `vs2` aligned to the 2× group; `vd` aligned to the 1× group; the 1× `vd` group not overlapping the 2× `vs2` group; and a vector `vs1` aligned to the 1× group.
- R9: Quad-widening (class 4) needs all of the following: multiplier ≤ 2; `sew_log2`+2 ≤ `elen_log2`; `vd` aligned to the 4× group; no overlap between the 4× `vd` group and any 1× source group; and each source aligned to the 1× group.
- R10: Mask-producing operations (class 5) with multiplier > 1 need each source aligned to the 1× group, and the one-register `vd` must not overlap any source group. With multiplier ≤ 1, class 5 is always legal.
- R11: Reductions (class 6) are illegal when `vstart_nz` = 1 or when `vs2` is misaligned to the 1× group. When `wide_red` = 1 they also need `sew_log2`+1 ≤ `elen_log2`.
- R12: Carry-using operations (class 7) follow the single-width rules. In addition, `vd` = 0 is illegal whenever the multiplier is not exactly 1.
- R13: Indexed loads (class 8) and stores (class 9) need `vd` and `vs2` aligned to the 1× group. For a load with `nf` ≠ 0, the two 1× groups must not overlap.
- R14: With `vm` = 0, `vd` = 0 is illegal for classes 0, 1, 2, 3, 4, 7, 8 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction strobe |
| op_class | input | 4 | Operation class code |
| vd | input | 5 | Destination register index |
| vs1 | input | 5 | First source index |
| vs2 | input | 5 | Second source index |
| vs1_is_vec | input | 1 | vs1 names a vector register group |
| wide_red | input | 1 | Reduction is widening |
| vm | input | 1 | Mask bit (0 = masked) |
| nf | input | 3 | Segment field count minus one |
| lmul_code | input | 3 | Group multiplier code |
| sew_log2 | input | 3 | log2 of element width in bits |
| elen_log2 | input | 3 | log2 of largest supported element width |
| vstart_nz | input | 1 | Start index is nonzero |
| res_valid | output | 1 | Verdict present |
| illegal | output | 1 | Strobed instruction is illegal |

## Verification
The only state is the three-valued verdict register, so a wrong internal state shows at the ports in the cycle right after the strobe. It appears there as a missing or extra `res_valid`, or as an `illegal` that disagrees with the rules. The verdict is rebuilt on every strobe, so an error lasts exactly one cycle and cannot hide in stored state. For that reason the bench compares both outputs on every cycle against a behavioural model. The stimulus mixes directed edge layouts (touching ranges, fractional rounding, reserved codes) with many random instructions.

// File: rtl/vgrp_pkg.sv
package vgrp_pkg;
    localparam int NUM_VREGS = 32;
    localparam int IDX_W     = $clog2(NUM_VREGS);
    localparam int SZ_W      = IDX_W + 1;
    localparam int END_W     = SZ_W + 1;
    localparam int NSCALE    = 3;   // 1x, 2x, 4x groups

    typedef enum logic [3:0] {
        CL_SINGLE = 4'd0,
        CL_WIDEN  = 4'd1,
        CL_WSRC   = 4'd2,
        CL_NARROW = 4'd3,
        CL_QUAD   = 4'd4,
        CL_MASK   = 4'd5,
        CL_RED    = 4'd6,
        CL_CARRY  = 4'd7,
        CL_IDX_LD = 4'd8,
        CL_IDX_ST = 4'd9,
        CL_SLIDE  = 4'd10
    } op_class_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LEGAL   = 2'd1,
        ST_ILLEGAL = 2'd2
    } res_state_e;

    // Index is a multiple of a power-of-two group size
    function automatic logic grp_aligned(logic [IDX_W-1:0] idx, logic [SZ_W-1:0] sz);
        return ((SZ_W'(idx) & (sz - SZ_W'(1))) == '0);
    endfunction

    // Two half-open ranges share a register; empty pair never overlaps
    function automatic logic grp_overlap(logic [IDX_W-1:0] a, logic [SZ_W-1:0] asz,
                                         logic [IDX_W-1:0] b, logic [SZ_W-1:0] bsz);
        logic [END_W-1:0] ae, be, hi, lo;
        if (asz == '0 && bsz == '0) return 1'b0;
        ae = END_W'(a) + END_W'(asz);
        be = END_W'(b) + END_W'(bsz);
        hi = (ae > be) ? ae : be;
        lo = (a < b) ? END_W'(a) : END_W'(b);
        return (hi - lo) < (END_W'(asz) + END_W'(bsz));
    endfunction
endpackage

// File: rtl/vgrp_sizes.sv
module vgrp_sizes
    import vgrp_pkg::*;
(
    input  logic [2:0]                   lmul_code,
    output logic [NSCALE-1:0][SZ_W-1:0]  gsz,
    output logic                         lmul_res,
    output logic                         lmul_gt1,
    output logic                         lmul_le4,
    output logic                         lmul_le2,
    output logic                         lmul_is1
);
    localparam int L8_W = 7;
    localparam int E8_W = L8_W + NSCALE;

    logic [L8_W-1:0] lmul8;   // multiplier in eighths of a register

    always_comb begin
        unique case (lmul_code)
            3'd0:    lmul8 = L8_W'(8);
            3'd1:    lmul8 = L8_W'(16);
            3'd2:    lmul8 = L8_W'(32);
            3'd3:    lmul8 = L8_W'(64);
            3'd5:    lmul8 = L8_W'(1);
            3'd6:    lmul8 = L8_W'(2);
            3'd7:    lmul8 = L8_W'(4);
            default: lmul8 = '0;
        endcase
    end

    for (genvar s = 0; s < NSCALE; s++) begin : g_scale
        logic [E8_W-1:0] eighths;
        assign eighths = E8_W'(lmul8) << s;
        assign gsz[s]  = SZ_W'((eighths + E8_W'(7)) >> 3);
    end

    assign lmul_res = (lmul_code == 3'd4);
    assign lmul_gt1 = (lmul_code >= 3'd1) && (lmul_code <= 3'd3);
    assign lmul_le4 = (lmul_code != 3'd3) && !lmul_res;
    assign lmul_le2 = (lmul_code != 3'd3) && (lmul_code != 3'd2) && !lmul_res;
    assign lmul_is1 = (lmul_code == 3'd0);
endmodule

// File: rtl/vgrp_rules.sv
module vgrp_rules
    import vgrp_pkg::*;
(
    input  logic [3:0]                   op_class,
    input  logic [IDX_W-1:0]             vd,
    input  logic [IDX_W-1:0]             vs1,
    input  logic [IDX_W-1:0]             vs2,
    input  logic                         vs1_is_vec,
    input  logic                         wide_red,
    input  logic                         vm,
    input  logic [2:0]                   nf,
    input  logic [2:0]                   sew_log2,
    input  logic [2:0]                   elen_log2,
    input  logic                         vstart_nz,
    input  logic [NSCALE-1:0][SZ_W-1:0]  gsz,
    input  logic                         lmul_res,
    input  logic                         lmul_gt1,
    input  logic                         lmul_le4,
    input  logic                         lmul_le2,
    input  logic                         lmul_is1,
    output logic                         bad
);
    logic [SZ_W-1:0] g1, g2, g4;
    logic            w2_ok, w4_ok, mask_vd0, vd_zero;
    op_class_e       cls;

    assign g1       = gsz[0];
    assign g2       = gsz[1];
    assign g4       = gsz[2];
    assign w2_ok    = (4'(sew_log2) + 4'd1) <= 4'(elen_log2);
    assign w4_ok    = (4'(sew_log2) + 4'd2) <= 4'(elen_log2);
    assign vd_zero  = (vd == '0);
    assign mask_vd0 = !vm && vd_zero;
    assign cls      = op_class_e'(op_class);

    always_comb begin
        bad = 1'b0;
        if (lmul_res) begin
            bad = 1'b1;
        end else begin
            unique case (cls)
                CL_SINGLE, CL_CARRY: begin
                    bad = mask_vd0;
                    if (lmul_gt1)
                        bad = bad | !grp_aligned(vd, g1) | !grp_aligned(vs2, g1)
                                  | (vs1_is_vec && !grp_aligned(vs1, g1));
                    if (cls == CL_CARRY && !lmul_is1 && vd_zero)
                        bad = 1'b1;
                end
                CL_WIDEN:
                    bad = mask_vd0 | !lmul_le4 | !w2_ok | !grp_aligned(vd, g2)
                        | grp_overlap(vd, g2, vs2, g1) | !grp_aligned(vs2, g1)
                        | (vs1_is_vec && (grp_overlap(vd, g2, vs1, g1) || !grp_aligned(vs1, g1)));
                CL_WSRC:
                    bad = mask_vd0 | !lmul_le4 | !w2_ok | !grp_aligned(vd, g2)
                        | !grp_aligned(vs2, g2)
                        | (vs1_is_vec && (grp_overlap(vd, g2, vs1, g1) || !grp_aligned(vs1, g1)));
                CL_NARROW:
                    bad = mask_vd0 | !lmul_le4 | !w2_ok | !grp_aligned(vs2, g2)
                        | !grp_aligned(vd, g1) | grp_overlap(vd, g1, vs2, g2)
                        | (vs1_is_vec && !grp_aligned(vs1, g1));
                CL_QUAD:
                    bad = mask_vd0 | !lmul_le2 | !w4_ok | !grp_aligned(vd, g4)
                        | grp_overlap(vd, g4, vs2, g1) | !grp_aligned(vs2, g1)
                        | (vs1_is_vec && (grp_overlap(vd, g4, vs1, g1) || !grp_aligned(vs1, g1)));
                CL_MASK:
                    bad = lmul_gt1 && (grp_overlap(vd, SZ_W'(1), vs2, g1) || !grp_aligned(vs2, g1)
                        || (vs1_is_vec && (grp_overlap(vd, SZ_W'(1), vs1, g1)
                                           || !grp_aligned(vs1, g1))));
                CL_RED:
                    bad = vstart_nz | !grp_aligned(vs2, g1) | (wide_red && !w2_ok);
                CL_IDX_LD:
                    bad = mask_vd0 | !grp_aligned(vd, g1) | !grp_aligned(vs2, g1)
                        | ((nf != 3'd0) && grp_overlap(vd, g1, vs2, g1));
                CL_IDX_ST:
                    bad = !grp_aligned(vd, g1) | !grp_aligned(vs2, g1);
                CL_SLIDE:
                    bad = mask_vd0 | !grp_aligned(vd, g1) | !grp_aligned(vs2, g1);
                default:
                    bad = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/vgrp_legal_chk.sv
module vgrp_legal_chk
    import vgrp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [3:0] op_class,
    input  logic [4:0] vd,
    input  logic [4:0] vs1,
    input  logic [4:0] vs2,
    input  logic       vs1_is_vec,
    input  logic       wide_red,
    input  logic       vm,
    input  logic [2:0] nf,
    input  logic [2:0] lmul_code,
    input  logic [2:0] sew_log2,
    input  logic [2:0] elen_log2,
    input  logic       vstart_nz,
    output logic       res_valid,
    output logic       illegal
);
    logic [NSCALE-1:0][SZ_W-1:0] gsz;
    logic lmul_res, lmul_gt1, lmul_le4, lmul_le2, lmul_is1, verdict_bad;
    res_state_e state_q, state_d;

    vgrp_sizes u_sizes (
        .lmul_code (lmul_code),
        .gsz       (gsz),
        .lmul_res  (lmul_res),
        .lmul_gt1  (lmul_gt1),
        .lmul_le4  (lmul_le4),
        .lmul_le2  (lmul_le2),
        .lmul_is1  (lmul_is1)
    );

    vgrp_rules u_rules (
        .op_class   (op_class),
        .vd         (vd),
        .vs1        (vs1),
        .vs2        (vs2),
        .vs1_is_vec (vs1_is_vec),
        .wide_red   (wide_red),
        .vm         (vm),
        .nf         (nf),
        .sew_log2   (sew_log2),
        .elen_log2  (elen_log2),
        .vstart_nz  (vstart_nz),
        .gsz        (gsz),
        .lmul_res   (lmul_res),
        .lmul_gt1   (lmul_gt1),
        .lmul_le4   (lmul_le4),
        .lmul_le2   (lmul_le2),
        .lmul_is1   (lmul_is1),
        .bad        (verdict_bad)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_LEGAL, ST_ILLEGAL:
                if (in_valid) state_d = verdict_bad ? ST_ILLEGAL : ST_LEGAL;
                else          state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        res_valid = (state_q != ST_IDLE);
        illegal   = (state_q == ST_ILLEGAL);
    end

    // R1
    strobe_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    // R1
    no_strobe_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid && !illegal);
    // R2
    reserved_lmul_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && lmul_code == 3'd4 |=> illegal);
    // R11
    red_vstart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_class == 4'd6 && vstart_nz |=> illegal);
    // R14
    masked_vd0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_class == 4'd0 && !vm && vd == 5'd0 |=> illegal);
    // R13
    store_unit_lmul_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_class == 4'd9 && lmul_code == 3'd0 |=> res_valid && !illegal);
endmodule

// File: tb/vgrp_legal_chk_tb.sv
`timescale 1ns/1ps
module vgrp_legal_chk_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [3:0] op_class = '0;
    logic [4:0] vd = '0, vs1 = '0, vs2 = '0;
    logic vs1_is_vec = 1'b0, wide_red = 1'b0, vm = 1'b1, vstart_nz = 1'b0;
    logic [2:0] nf = '0, lmul_code = '0, sew_log2 = 3'd3, elen_log2 = 3'd6;
    logic res_valid, illegal;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vgrp_legal_chk u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_class(op_class),
        .vd(vd), .vs1(vs1), .vs2(vs2), .vs1_is_vec(vs1_is_vec), .wide_red(wide_red),
        .vm(vm), .nf(nf), .lmul_code(lmul_code), .sew_log2(sew_log2),
        .elen_log2(elen_log2), .vstart_nz(vstart_nz), .res_valid(res_valid),
        .illegal(illegal)
    );

    function automatic bit is_al(int idx, int sz);
        return (idx % sz) == 0;
    endfunction

    function automatic bit is_ov(int a, int n, int b, int m);
        int hi, lo;
        if (n == 0 && m == 0) return 1'b0;
        hi = (a + n > b + m) ? a + n : b + m;
        lo = (a < b) ? a : b;
        return (hi - lo) < (n + m);
    endfunction

    // Behavioural reference for the current stimulus
    function automatic bit ref_bad();
        int e, s1, s2, s4, d, a, b;
        bit w2, w4, mz, bad;
        case (lmul_code)
            3'd0: e = 8;  3'd1: e = 16; 3'd2: e = 32; 3'd3: e = 64;
            3'd5: e = 1;  3'd6: e = 2;  3'd7: e = 4;
            default: return 1'b1;
        endcase
        s1 = (e + 7) / 8; s2 = (2 * e + 7) / 8; s4 = (4 * e + 7) / 8;
        d = vd; a = vs1; b = vs2;
        w2 = (sew_log2 + 1) <= elen_log2;
        w4 = (sew_log2 + 2) <= elen_log2;
        mz = (vm == 1'b0) && (d == 0);
        bad = 1'b0;
        case (op_class)
            4'd0, 4'd7: begin
                bad = mz || !is_al(d, s1) || !is_al(b, s1) || (vs1_is_vec && !is_al(a, s1));
                if (op_class == 4'd7 && e != 8 && d == 0) bad = 1'b1;
            end
            4'd1: bad = mz || e > 32 || !w2 || !is_al(d, s2) || is_ov(d, s2, b, s1)
                        || !is_al(b, s1) || (vs1_is_vec && (is_ov(d, s2, a, s1) || !is_al(a, s1)));
            4'd2: bad = mz || e > 32 || !w2 || !is_al(d, s2) || !is_al(b, s2)
                        || (vs1_is_vec && (is_ov(d, s2, a, s1) || !is_al(a, s1)));
            4'd3: bad = mz || e > 32 || !w2 || !is_al(b, s2) || !is_al(d, s1)
                        || is_ov(d, s1, b, s2) || (vs1_is_vec && !is_al(a, s1));
            4'd4: bad = mz || e > 16 || !w4 || !is_al(d, s4) || is_ov(d, s4, b, s1)
                        || !is_al(b, s1) || (vs1_is_vec && (is_ov(d, s4, a, s1) || !is_al(a, s1)));
            4'd5: bad = (e > 8) && (is_ov(d, 1, b, s1) || !is_al(b, s1)
                        || (vs1_is_vec && (is_ov(d, 1, a, s1) || !is_al(a, s1))));
            4'd6: bad = vstart_nz || !is_al(b, s1) || (wide_red && !w2);
            4'd8: bad = mz || !is_al(d, s1) || !is_al(b, s1) || (nf != 0 && is_ov(d, s1, b, s1));
            4'd9: bad = !is_al(d, s1) || !is_al(b, s1);
            4'd10: bad = mz || !is_al(d, s1) || !is_al(b, s1);
            default: bad = 1'b1;
        endcase
        return bad;
    endfunction

    function automatic string tag_of(logic [3:0] c);
        case (c)
            4'd0: return "R5";  4'd1: return "R6";  4'd2: return "R7";
            4'd3: return "R8";  4'd4: return "R9";  4'd5: return "R10";
            4'd6: return "R11"; 4'd7: return "R12"; 4'd8, 4'd9: return "R13";
            4'd10: return "R5"; default: return "R2";
        endcase
    endfunction

    task automatic base(input logic [3:0] c, input logic [2:0] lc);
        op_class = c; lmul_code = lc; vd = '0; vs1 = '0; vs2 = '0;
        vs1_is_vec = 1'b0; wide_red = 1'b0; vm = 1'b1; nf = '0;
        sew_log2 = 3'd3; elen_log2 = 3'd6; vstart_nz = 1'b0;
    endtask

    // Inputs are set at a falling edge; result is compared at the next falling edge
    task automatic step(input bit v, input string tag);
        bit exp_ill;
        in_valid = v;
        exp_ill = v && ref_bad();
        @(negedge clk);
        checks++;
        if (res_valid !== v || illegal !== exp_ill) begin
            fails++;
            $display("FAIL %s: res_valid=%0b illegal=%0b expected res_valid=%0b illegal=%0b",
                     tag, res_valid, illegal, v, exp_ill);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || illegal !== 1'b0) begin
            fails++;
            $display("FAIL R1: reset res_valid=%0b illegal=%0b expected 0 0", res_valid, illegal);
        end
        rst_n = 1'b1;
        step(1'b0, "R1");
        base(4'd0, 3'd4); step(1'b1, "R2");                        // reserved multiplier
        base(4'd12, 3'd0); step(1'b1, "R2");                       // reserved class
        base(4'd0, 3'd1); vd = 5'd3; step(1'b1, "R3");             // misaligned vd, lmul 2
        base(4'd0, 3'd1); vd = 5'd4; vs2 = 5'd2; vs1 = 5'd5; step(1'b1, "R5"); // scalar vs1 ignored
        base(4'd1, 3'd0); vd = 5'd2; vs2 = 5'd3; step(1'b1, "R6");
        base(4'd1, 3'd0); vd = 5'd2; vs2 = 5'd4; step(1'b1, "R6");
        base(4'd1, 3'd3); vd = 5'd0; vs2 = 5'd16; step(1'b1, "R6");
        base(4'd2, 3'd1); vd = 5'd4; vs2 = 5'd2; step(1'b1, "R7");
        base(4'd2, 3'd1); vd = 5'd8; vs2 = 5'd4; vs1 = 5'd10; vs1_is_vec = 1'b1; step(1'b1, "R7");
        base(4'd3, 3'd0); vd = 5'd4; vs2 = 5'd4; step(1'b1, "R8");
        base(4'd3, 3'd0); vd = 5'd2; vs2 = 5'd0; step(1'b1, "R4"); // touching ranges
        base(4'd4, 3'd7); vd = 5'd1; vs2 = 5'd5; step(1'b1, "R9");
        base(4'd4, 3'd7); vd = 5'd2; vs2 = 5'd5; step(1'b1, "R9");
        base(4'd5, 3'd2); vd = 5'd5; vs2 = 5'd4; step(1'b1, "R10");
        base(4'd5, 3'd2); vd = 5'd0; vs2 = 5'd4; step(1'b1, "R10");
        base(4'd5, 3'd0); vd = 5'd4; vs2 = 5'd4; step(1'b1, "R10");
        base(4'd6, 3'd0); vstart_nz = 1'b1; step(1'b1, "R11");
        base(4'd6, 3'd0); wide_red = 1'b1; sew_log2 = 3'd6; step(1'b1, "R11");
        base(4'd7, 3'd7); vd = 5'd0; step(1'b1, "R12");
        base(4'd7, 3'd0); vd = 5'd0; step(1'b1, "R12");
        base(4'd8, 3'd0); vd = 5'd2; vs2 = 5'd2; nf = 3'd1; step(1'b1, "R13");
        base(4'd9, 3'd0); vd = 5'd2; vs2 = 5'd2; nf = 3'd1; step(1'b1, "R13");
        base(4'd10, 3'd0); vm = 1'b0; step(1'b1, "R14");
        step(1'b0, "R1");
        for (int i = 0; i < 4000; i++) begin
            op_class   = 4'($urandom_range(0, 11));
            lmul_code  = 3'($urandom);
            vd         = (($urandom % 3) == 0) ? 5'd0 : 5'($urandom);
            vs1        = 5'($urandom);
            vs2        = 5'($urandom);
            vs1_is_vec = 1'($urandom);
            wide_red   = 1'($urandom);
            vm         = 1'($urandom);
            nf         = 3'($urandom);
            sew_log2   = 3'($urandom_range(3, 6));
            elen_log2  = 3'($urandom_range(5, 6));
            vstart_nz  = (($urandom % 4) == 0);
            step((($urandom % 8) != 0), (!vm && vd == 0) ? "R14" : tag_of(op_class));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule